// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block is an eight-bit parallel port that moves bytes between a host and an outside device under a two-wire handshake. It works in one of two directions at a time. In the receive direction the outside device places a byte on the pins and pulses an active-low strobe. The port captures the byte and raises a buffer-full flag. When the strobe returns high it requests an interrupt. The host takes the byte with a read pulse, which drops the interrupt and then empties the buffer.

In the send direction a host write pulse drops any pending interrupt. Its trailing edge puts the byte on the pins and pulls an active-low output-full flag low. The outside device answers with an active-low acknowledge. Its leading edge releases the full flag and its trailing edge requests an interrupt. A mask bit for each direction gates the interrupt pin and leaves the flags alone.

The strobe and acknowledge arrive from outside the clock domain. They pass through a parameterised synchronizer before any edge is detected. The host read and write strobes are synchronous levels, and their edges are taken with a single register. This port has no valid/ready stream: every exchange follows the strobe handshake. Back-pressure is the flags themselves, and neither side is stalled by the block.

Top module: `hsport`

## Requirements
- R1: After reset the pins are not driven (pin_oe=0), ibf=0, obf_n=1 and intr=0.
- R2: In receive direction (dir_sel=0) a falling edge of ext_stb_n captures pin_in into host_rdata and sets ibf. A later strobe overwrites the captured byte.
- R3: In receive direction an interrupt request is raised when ext_stb_n returns high while ibf=1. The interrupt stays low while the strobe is still low.
- R4: A falling edge of host_rd_n clears the receive interrupt and leaves ibf at 1. The following rising edge of host_rd_n clears ibf, and host_rdata keeps the byte.
- R5: In send direction (dir_sel=1) a falling edge of host_wr_n clears the send interrupt. The rising edge of host_wr_n places host_wdata on pin_out and drives obf_n to 0.
- R6: A falling edge of ext_ack_n in send direction drives obf_n to 1.
- R7: A rising edge of ext_ack_n in send direction raises an interrupt request when obf_n=1.
- R8: intr is the pending request of the active direction ANDed with that direction's enable (ie_in or ie_out). Changing an enable changes only intr, never ibf, obf_n or a pending request.
- R9: pin_oe follows dir_sel one clock later. The clock edge on which the direction changes clears ibf, sets obf_n to 1 and drops both pending requests.
- R10: The acknowledge and host writes have no effect in receive direction. The strobe has no effect in send direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_sel | input | 1 | Direction select: 0 receive, 1 send |
| ie_in | input | 1 | Receive interrupt enable |
| ie_out | input | 1 | Send interrupt enable |
| host_rd_n | input | 1 | Host read strobe, active low, synchronous |
| host_wr_n | input | 1 | Host write strobe, active low, synchronous |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Last byte captured from the pins |
| ext_stb_n | input | 1 | External strobe, active low, asynchronous |
| ext_ack_n | input | 1 | External acknowledge, active low, asynchronous |
| pin_in | input | 8 | Byte presented by the outside device |
| pin_out | output | 8 | Byte driven toward the outside device |
| pin_oe | output | 1 | Pin driver enable, high in send direction |
| ibf | output | 1 | Receive buffer full |
| obf_n | output | 1 | Send buffer full, active low |
| intr | output | 1 | Masked interrupt request |

## Verification
The bench checks that the receive interrupt waits for the trailing edge of the strobe. A design that fired on the leading edge would show intr while the strobe is still low. It also checks that a read splits its two effects across its two edges. A design that cleared the flag on the leading edge would show ibf=0 while the read is still low. Masked transactions are followed by unmasking, which exposes a design that lost the request or cleared a flag through the mask. Acknowledge and write pulses in receive direction, strobes in send direction, and a direction change with a pending byte show whether stale requests or flags survive.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } edge_t;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/hsport_edge.sv
module hsport_edge
  import hsport_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  din,
  output edge_t ev,
  output logic  lvl
);
  logic prev_q;

  generate
    if (STAGES > 0) begin : g_sync
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q[0] <= din;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign lvl = chain_q[STAGES-1];
    end else begin : g_direct
      assign lvl = din;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  assign ev.fall = prev_q & ~lvl;
  assign ev.rise = ~prev_q & lvl;
endmodule

// File: rtl/hsport_rx.sv
module hsport_rx
  import hsport_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         clear,
  input  edge_t        stb,
  input  edge_t        rd,
  input  logic [W-1:0] pin_in,
  output logic         full,
  output logic         req,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      req  <= 1'b0;
      data <= '0;
    end else if (clear) begin
      full <= 1'b0;
      req  <= 1'b0;
    end else if (active) begin
      if (stb.fall) begin
        data <= pin_in;
        full <= 1'b1;
      end
      if (stb.rise && full) req <= 1'b1;
      if (rd.fall) req <= 1'b0;
      if (rd.rise) full <= 1'b0;
    end
  end
endmodule

// File: rtl/hsport_tx.sv
module hsport_tx
  import hsport_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         clear,
  input  edge_t        ack,
  input  edge_t        wr,
  input  logic [W-1:0] wdata,
  output logic         full_n,
  output logic         req,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_n <= 1'b1;
      req    <= 1'b0;
      dout   <= '0;
    end else if (clear) begin
      full_n <= 1'b1;
      req    <= 1'b0;
    end else if (active) begin
      if (wr.fall) req <= 1'b0;
      if (wr.rise) begin
        dout   <= wdata;
        full_n <= 1'b0;
      end
      if (ack.fall) full_n <= 1'b1;
      if (ack.rise && full_n) req <= 1'b1;
    end
  end
endmodule

// File: rtl/hsport.sv
module hsport
  import hsport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_sel,
  input  logic              ie_in,
  input  logic              ie_out,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ext_stb_n,
  input  logic              ext_ack_n,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic              pin_oe,
  output logic              ibf,
  output logic              obf_n,
  output logic              intr
);
  dir_e  mode_q;
  logic  mode_chg;
  logic  rx_act, tx_act;
  edge_t stb_ev, ack_ev, rd_ev, wr_ev;
  logic  stb_lvl, ack_lvl, rd_lvl, wr_lvl;
  logic  rx_req, tx_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= DIR_RX;
    else        mode_q <= dir_e'(dir_sel);
  end

  assign mode_chg = (mode_q != dir_e'(dir_sel));
  assign rx_act   = !mode_chg && (mode_q == DIR_RX);
  assign tx_act   = !mode_chg && (mode_q == DIR_TX);

  hsport_edge #(.STAGES(SYNC_STAGES)) u_stb (
    .clk(clk), .rst_n(rst_n), .din(ext_stb_n), .ev(stb_ev), .lvl(stb_lvl));
  hsport_edge #(.STAGES(SYNC_STAGES)) u_ack (
    .clk(clk), .rst_n(rst_n), .din(ext_ack_n), .ev(ack_ev), .lvl(ack_lvl));
  hsport_edge #(.STAGES(0)) u_rd (
    .clk(clk), .rst_n(rst_n), .din(host_rd_n), .ev(rd_ev), .lvl(rd_lvl));
  hsport_edge #(.STAGES(0)) u_wr (
    .clk(clk), .rst_n(rst_n), .din(host_wr_n), .ev(wr_ev), .lvl(wr_lvl));

  hsport_rx #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(rx_act), .clear(mode_chg),
    .stb(stb_ev), .rd(rd_ev), .pin_in(pin_in),
    .full(ibf), .req(rx_req), .data(host_rdata));

  hsport_tx #(.W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(tx_act), .clear(mode_chg),
    .ack(ack_ev), .wr(wr_ev), .wdata(host_wdata),
    .full_n(obf_n), .req(tx_req), .dout(pin_out));

  assign pin_oe = (mode_q == DIR_TX);
  assign intr   = (mode_q == DIR_RX) ? (rx_req & ie_in) : (tx_req & ie_out);
endmodule

// File: rtl/hsport_chk.sv
module hsport_chk (
  input logic clk,
  input logic rst_n,
  input logic host_wr_n,
  input logic ie_in,
  input logic ie_out,
  input logic pin_oe,
  input logic ibf,
  input logic obf_n,
  input logic intr
);
  // R9
  ibf_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> !pin_oe);

  // R5
  obf_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obf_n) |-> pin_oe && $past(host_wr_n) && !$past(host_wr_n, 2));

  // R8
  intr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> (ie_in && !pin_oe) || (ie_out && pin_oe));

  // R10
  rx_no_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> obf_n);

  // R10
  tx_no_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> !ibf);
endmodule

bind hsport hsport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr_n(host_wr_n), .ie_in(ie_in),
  .ie_out(ie_out), .pin_oe(pin_oe), .ibf(ibf), .obf_n(obf_n), .intr(intr));

// File: tb/tb_hsport.sv
module tb_hsport;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_sel = 1'b0, ie_in = 1'b0, ie_out = 1'b0;
  logic       host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [7:0] host_wdata = '0, pin_in = '0;
  logic       ext_stb_n = 1'b1, ext_ack_n = 1'b1;
  logic [7:0] host_rdata, pin_out;
  logic       pin_oe, ibf, obf_n, intr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsport dut (
    .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel), .ie_in(ie_in), .ie_out(ie_out),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ext_stb_n(ext_stb_n), .ext_ack_n(ext_ack_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ibf(ibf),
    .obf_n(obf_n), .intr(intr));

  function automatic logic exp_intr(input logic en, input logic pending);
    return en & pending;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_dir(input logic d);
    dir_sel = d;
    tick(2);
  endtask

  task automatic strobe(input logic [7:0] d, input logic ie);
    pin_in = d;
    tick(1);
    ext_stb_n = 1'b0;
    tick(6);
    chk("R2 ibf set", {7'd0, ibf}, 8'd1);
    chk("R2 data", host_rdata, d);
    chk("R3 no intr while low", {7'd0, intr}, 8'd0);
    ext_stb_n = 1'b1;
    tick(6);
    chk("R3 intr after rise", {7'd0, intr}, {7'd0, exp_intr(ie, 1'b1)});
  endtask

  task automatic host_read(input logic [7:0] d);
    host_rd_n = 1'b0;
    tick(3);
    chk("R4 intr cleared", {7'd0, intr}, 8'd0);
    chk("R4 ibf held", {7'd0, ibf}, 8'd1);
    host_rd_n = 1'b1;
    tick(3);
    chk("R4 ibf cleared", {7'd0, ibf}, 8'd0);
    chk("R4 data kept", host_rdata, d);
  endtask

  task automatic host_write(input logic [7:0] d);
    host_wdata = d;
    host_wr_n = 1'b0;
    tick(3);
    chk("R5 intr cleared", {7'd0, intr}, 8'd0);
    host_wr_n = 1'b1;
    tick(3);
    chk("R5 obf_n low", {7'd0, obf_n}, 8'd0);
    chk("R5 pin_out", pin_out, d);
  endtask

  task automatic ack(input logic ie);
    ext_ack_n = 1'b0;
    tick(6);
    chk("R6 obf_n high", {7'd0, obf_n}, 8'd1);
    chk("R7 no intr while low", {7'd0, intr}, 8'd0);
    ext_ack_n = 1'b1;
    tick(6);
    chk("R7 intr after rise", {7'd0, intr}, {7'd0, exp_intr(ie, 1'b1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       e;
    void'($urandom(32'd1234));
    tick(4);
    chk("R1 pin_oe", {7'd0, pin_oe}, 8'd0);
    chk("R1 ibf", {7'd0, ibf}, 8'd0);
    chk("R1 obf_n", {7'd0, obf_n}, 8'd1);
    chk("R1 intr", {7'd0, intr}, 8'd0);
    rst_n = 1'b1;
    tick(3);

    // receive direction
    ie_in = 1'b1;
    strobe(8'hA5, 1'b1);
    host_read(8'hA5);
    // R2 overwrite by a second strobe before read
    ie_in = 1'b0;
    strobe(8'h11, 1'b0);
    strobe(8'h3C, 1'b0);
    chk("R2 overwrite", host_rdata, 8'h3C);
    // R8 unmask exposes the held request, flags untouched
    ie_in = 1'b1;
    tick(1);
    chk("R8 unmask intr", {7'd0, intr}, 8'd1);
    chk("R8 ibf unchanged", {7'd0, ibf}, 8'd1);
    host_read(8'h3C);

    // R10 ack and write ignored in receive direction
    ext_ack_n = 1'b0; tick(6); ext_ack_n = 1'b1; tick(6);
    host_wdata = 8'hEE; host_wr_n = 1'b0; tick(3); host_wr_n = 1'b1; tick(3);
    chk("R10 obf_n rx", {7'd0, obf_n}, 8'd1);
    chk("R10 intr rx", {7'd0, intr}, 8'd0);
    chk("R10 pin_out rx", pin_out, 8'h00);

    // send direction
    set_dir(1'b1);
    chk("R9 pin_oe on", {7'd0, pin_oe}, 8'd1);
    ie_out = 1'b1;
    host_write(8'h5A);
    ack(1'b1);
    host_write(8'hC3);
    // R10 strobe ignored in send direction
    pin_in = 8'h77;
    ext_stb_n = 1'b0; tick(6); ext_stb_n = 1'b1; tick(6);
    chk("R10 ibf tx", {7'd0, ibf}, 8'd0);
    chk("R10 rdata tx", host_rdata, 8'h3C);
    chk("R10 obf_n held", {7'd0, obf_n}, 8'd0);
    // R9 direction change with pending byte
    set_dir(1'b0);
    chk("R9 pin_oe off", {7'd0, pin_oe}, 8'd0);
    chk("R9 obf_n cleared", {7'd0, obf_n}, 8'd1);
    chk("R9 intr cleared", {7'd0, intr}, 8'd0);

    // random mix
    for (int i = 0; i < 30; i++) begin
      logic dsel;
      dsel = 1'($urandom_range(0, 1));
      d = 8'($urandom);
      e = 1'($urandom_range(0, 1));
      set_dir(dsel);
      if (!dsel) begin
        ie_in = e;
        strobe(d, e);
        host_read(d);
      end else begin
        ie_out = e;
        host_write(d);
        ack(e);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule